// File: doc/BRIEF.md
# Syndrome Coset Rewriting Encoder for Write-Once Cells

This block lets a 3-bit value be rewritten several times into a group of seven binary cells that can only move from 0 to 1 between erasures. The value is never stored directly. Instead it is carried as the syndrome of the cell vector under a (7,4) Hamming parity-check matrix. Column j of that matrix is the binary value of j, and it belongs to cell bit j-1. Reading the value back is therefore only a syndrome computation on the cells.

On a write, the block takes the XOR of the requested value with the current syndrome. It then adds the fewest new 1s that bring the syndrome to the requested value. One cell is enough when the matching column is still free. Otherwise a pair of free cells whose columns combine to the difference is used. When neither exists, the group is exhausted. A flag then reports this until the controller erases the group. The cell vector is an output, so a physical programming stage can follow the block.

Top module: `wom_coset_encoder`

## Requirements
- R1: After reset, cellState is 0000000, rdData is 000, memFull is 0 and doneOut is 0.
- R2: Between erasures a cell that holds 1 never returns to 0. cellState only gains bits.
- R3: rdData is the XOR of the values (i+1) over every cell bit i of cellState that is 1. It follows cellState in the same cycle.
- R4: A write that can be stored makes rdData equal to wrData from the cycle after the strobe. A write of the value already held leaves cellState unchanged.
- R5: Let d be wrData XOR rdData, with d nonzero. If cell bit d-1 is 0, the write sets exactly that one bit.
- R6: If cell bit d-1 is already 1, the write sets the two clear bits a<b with (a+1) XOR (b+1) = d. It takes the lowest a, then the lowest b.
- R7: If no single bit or pair fits, cellState is unchanged and memFull rises in the next cycle. memFull then stays high, and every write is ignored until erase.
- R8: eraseIn clears cellState and memFull on the next edge. It wins over a write in the same cycle, and that write gives no doneOut.
- R9: doneOut is high for exactly the one cycle that follows each write strobe not coinciding with erase. This includes writes that fail or are ignored.
- R10: Starting from the erased state, any three consecutive writes of arbitrary data are all stored, and memFull stays 0 through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| eraseIn | input | 1 | Erase request for the whole cell group |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 3 | Value to be stored as syndrome |
| cellState | output | 7 | Current cell levels, bit i has parity column i+1 |
| rdData | output | 3 | Decoded value (syndrome of cellState) |
| doneOut | output | 1 | One-cycle pulse after each write strobe |
| memFull | output | 1 | Group exhausted, erase needed |

## Verification
cellState, memFull and doneOut all change on the edge that samples a write or erase. They are visible for one cycle after it. rdData is combinational from cellState, so it follows in that same cycle. The bench drives each strobe on a falling edge and samples every output on the next falling edge, half a cycle after the single register stage. doneOut drops on the following edge, so the bench samples it inside that one window and once more after it to confirm the pulse length.

// File: rtl/wom_pkg.sv
package wom_pkg;
  // Strobes from the control to the cell datapath.
  typedef struct packed {
    logic clearCells;
    logic commitCells;
  } wom_strobe_t;
endpackage

// File: rtl/wom_datapath.sv
module wom_datapath #(
  parameter int SYN_W = 3,
  localparam int CELLS = (1 << SYN_W) - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  wom_pkg::wom_strobe_t strb,
  input  logic [SYN_W-1:0]     wrData,
  output logic [CELLS-1:0]     cellQ,
  output logic [SYN_W-1:0]     synOut,
  output logic                 solvable
);
  logic [SYN_W-1:0] diff;
  logic [CELLS-1:0] singleMask;
  logic [CELLS-1:0] pairMask;
  logic [CELLS-1:0] addMask;
  logic             singleHit;
  logic             pairHit;

  // Syndrome of current cells: column for bit i is i+1.
  always_comb begin
    synOut = '0;
    for (int i = 0; i < CELLS; i++) begin
      if (cellQ[i]) synOut = synOut ^ SYN_W'(i + 1);
    end
  end

  assign diff = wrData ^ synOut;

  // Single-cell candidates, one per column.
  genvar g;
  generate
    for (g = 0; g < CELLS; g++) begin : g_single
      assign singleMask[g] = (diff == SYN_W'(g + 1)) && !cellQ[g];
    end
  endgenerate

  assign singleHit = |singleMask;

  // Pair search: lowest first index, then lowest second index.
  always_comb begin
    pairMask = '0;
    pairHit  = 1'b0;
    for (int a = 0; a < CELLS; a++) begin
      for (int b = a + 1; b < CELLS; b++) begin
        if (!pairHit && !cellQ[a] && !cellQ[b] &&
            ((SYN_W'(a + 1) ^ SYN_W'(b + 1)) == diff)) begin
          pairHit     = 1'b1;
          pairMask[a] = 1'b1;
          pairMask[b] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (diff == '0)     addMask = '0;
    else if (singleHit) addMask = singleMask;
    else if (pairHit)   addMask = pairMask;
    else                addMask = '0;
  end

  assign solvable = (diff == '0) || singleHit || pairHit;

  always_ff @(posedge clk) begin
    if (rst)                   cellQ <= '0;
    else if (strb.clearCells)  cellQ <= '0;
    else if (strb.commitCells) cellQ <= cellQ | addMask;
  end

  AST_CELLS_MONOTONE: assert property (@(posedge clk) disable iff (rst)
    !strb.clearCells |=> ((cellQ & $past(cellQ)) == $past(cellQ))); // R2

  AST_MIN_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    strb.commitCells |=> ($countones(cellQ ^ $past(cellQ)) <= 2)); // R5

  AST_SAME_DATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    (strb.commitCells && wrData == synOut) |=> $stable(cellQ)); // R4
endmodule

// File: rtl/wom_ctrl.sv
module wom_ctrl (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 eraseIn,
  input  logic                 wrEn,
  input  logic                 solvable,
  output wom_pkg::wom_strobe_t strb,
  output logic                 doneQ,
  output logic                 fullQ
);
  typedef enum logic {ST_OPEN, ST_FULL} state_t;
  state_t state;

  always_comb begin
    strb.clearCells  = eraseIn;
    strb.commitCells = wrEn && !eraseIn && (state == ST_OPEN) && solvable;
  end

  assign fullQ = (state == ST_FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_OPEN;
      doneQ <= 1'b0;
    end else begin
      doneQ <= wrEn && !eraseIn;
      if (eraseIn)
        state <= ST_OPEN;
      else if (wrEn && state == ST_OPEN && !solvable)
        state <= ST_FULL;
    end
  end

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fullQ && !eraseIn) |=> fullQ); // R7

  AST_ERASE_OPENS: assert property (@(posedge clk) disable iff (rst)
    eraseIn |=> (!fullQ && !doneQ)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !eraseIn) |=> doneQ); // R9
endmodule

// File: rtl/wom_coset_encoder.sv
module wom_coset_encoder #(
  parameter int SYN_W = 3,
  localparam int CELLS = (1 << SYN_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eraseIn,
  input  logic             wrEn,
  input  logic [SYN_W-1:0] wrData,
  output logic [CELLS-1:0] cellState,
  output logic [SYN_W-1:0] rdData,
  output logic             doneOut,
  output logic             memFull
);
  wom_pkg::wom_strobe_t strb;
  logic solvable;

  wom_ctrl u_ctrl (
    .clk(clk), .rst(rst), .eraseIn(eraseIn), .wrEn(wrEn),
    .solvable(solvable), .strb(strb), .doneQ(doneOut), .fullQ(memFull)
  );

  wom_datapath #(.SYN_W(SYN_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData),
    .cellQ(cellState), .synOut(rdData), .solvable(solvable)
  );

  AST_DECODE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !eraseIn && !memFull && solvable) |=> (rdData == $past(wrData))); // R4

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !eraseIn && !solvable) |=> ($stable(cellState) && memFull)); // R7
endmodule

// File: tb/wom_coset_encoder_bench.sv
`timescale 1ns/1ps
module wom_coset_encoder_bench;
  logic clk = 1'b0;
  logic rst, eraseIn, wrEn;
  logic [2:0] wrData;
  logic [6:0] cellState;
  logic [2:0] rdData;
  logic doneOut, memFull;

  int checks = 0;
  int errors = 0;
  logic [6:0] mCells;
  logic mFull;
  int sinceErase;

  always #10 clk = ~clk;

  wom_coset_encoder u_wom_coset_encoder (
    .clk(clk), .rst(rst), .eraseIn(eraseIn), .wrEn(wrEn), .wrData(wrData),
    .cellState(cellState), .rdData(rdData), .doneOut(doneOut), .memFull(memFull)
  );

  function automatic logic [2:0] synOf(input logic [6:0] c);
    logic [2:0] s = 3'd0;
    for (int i = 0; i < 7; i++) if (c[i]) s = s ^ 3'(i + 1);
    return s;
  endfunction

  // Returns {fail, newCells} per R4..R7.
  function automatic logic [7:0] modelWrite(input logic [6:0] c, input logic [2:0] d);
    logic [2:0] df = d ^ synOf(c);
    if (df == 3'd0) return {1'b0, c};
    if (!c[df - 3'd1]) return {1'b0, c | (7'd1 << (df - 3'd1))};
    for (int a = 0; a < 7; a++)
      for (int b = a + 1; b < 7; b++)
        if (!c[a] && !c[b] && ((3'(a + 1) ^ 3'(b + 1)) == df))
          return {1'b0, c | (7'd1 << a) | (7'd1 << b)};
    return {1'b1, c};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] d, input string tag);
    logic [7:0] r;
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    if (!mFull) begin
      r = modelWrite(mCells, d);
      mCells = r[6:0];
      mFull = r[7];
    end
    sinceErase++;
    @(negedge clk);
    wrEn = 1'b0;
    chk({tag, " cells"}, 32'(cellState), 32'(mCells));
    chk("R3 decode", 32'(rdData), 32'(synOf(mCells)));
    chk("R7 full", 32'(memFull), 32'(mFull));
    chk("R9 done", 32'(doneOut), 32'd1);
    if (sinceErase <= 3) chk("R10 three writes", 32'(memFull), 32'd0);
  endtask

  task automatic doErase(input logic withWrite);
    @(negedge clk);
    eraseIn = 1'b1; wrEn = withWrite; wrData = 3'd7;
    @(negedge clk);
    eraseIn = 1'b0; wrEn = 1'b0;
    mCells = '0; mFull = 1'b0; sinceErase = 0;
    chk("R8 erase cells", 32'(cellState), 32'd0);
    chk("R8 erase full", 32'(memFull), 32'd0);
    chk("R8 no done", 32'(doneOut), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seedVal;
    seedVal = $urandom(32'd1234);
    rst = 1'b1; eraseIn = 1'b0; wrEn = 1'b0; wrData = 3'd0;
    mCells = '0; mFull = 1'b0; sinceErase = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cells", 32'(cellState), 32'd0);
    chk("R1 data", 32'(rdData), 32'd0);
    chk("R1 full", 32'(memFull), 32'd0);
    chk("R1 done", 32'(doneOut), 32'd0);

    // Example chain 000 -> 101 -> 110 -> 000
    doWrite(3'b101, "R5 single");
    chk("R5 bit4 only", 32'(cellState), 32'h10);
    doWrite(3'b110, "R5 single");
    chk("R4 data 110", 32'(rdData), 32'h6);
    doWrite(3'b000, "R5 single");
    chk("R5 cells 0110100", 32'(cellState), 32'h34);
    doWrite(3'b000, "R4 same");
    chk("R4 unchanged", 32'(cellState), 32'h34);
    @(negedge clk);
    chk("R9 pulse one cycle", 32'(doneOut), 32'd0);

    // Pair path and exhaustion
    doErase(1'b1);
    doWrite(3'b110, "R5 single");
    doWrite(3'b000, "R6 pair");
    chk("R6 pair bits 0,6", 32'(cellState), 32'h61);
    doWrite(3'b001, "R6 pair");
    chk("R6 pair bits 1,2", 32'(cellState), 32'h67);
    doWrite(3'b000, "R6 pair");
    chk("R6 all set", 32'(cellState), 32'h7f);
    doWrite(3'b111, "R7 fail");
    chk("R7 full set", 32'(memFull), 32'd1);
    chk("R2 cells kept", 32'(cellState), 32'h7f);
    doWrite(3'b000, "R7 ignored");
    chk("R7 still full", 32'(memFull), 32'd1);
    doErase(1'b0);

    // Constrained random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[3:0] == 4'd0) doErase(rv[4]);
      else doWrite(3'(rv[10:8]), "R2 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule